// File: doc/BRIEF.md
# Three-Phase Stored-Pattern Switching Sequencer

This block replays a precomputed switching pattern onto the three phase legs of a multilevel inverter. A free-running oscillator clock is divided by a programmable integer to make a step tick. One output period is 2048 steps, so the divisor is chosen so that the clock rate divided by the divisor equals 2048 times the wanted output frequency. With a 60 Hz output, one step lasts about 8.14 µs.

Only the first half of the period is stored: a 1024-word table of 12-bit switch words. Each word is six cells of two bits. Bit 2i is set when cell i conducts, and bit 2i+1 gives its polarity (1 means negative). Three step counters, one per phase, run at the same rate but hold fixed offsets. Each counter folds at mid-period into the same table. In the second half, the polarity bit of every conducting cell is flipped. After each tick, one read port serves the three phases in turn over three clocks, and all three output words are then loaded on one clock. The table is filled through a simple write port, and the divisor through a second one.

Top module: `tri_phase_pattern_seq`

## Requirements
- R1: During reset and until the first output update, all three phase outputs are all-zero (every cell off).
- R2: A step tick occurs every D clocks, where D is the active divisor. All three outputs change exactly 4 clocks after the tick edge and never at any other time.
- R3: A divisor write is held pending and becomes active at the next tick. The interval in progress keeps the old divisor, and the interval after that next tick uses the new one.
- R4: A divisor value below 4 is used as 4.
- R5: Phase A's step is k mod 2048 for the k-th update after reset (counting from 0). Its output word is the table word at address step[9:0].
- R6: Phase B's step leads phase A by 683 and phase C's by 1365, both modulo 2048.
- R7: When step bit 10 is 0, the table word is output unchanged. When it is 1, bit 2i+1 is inverted for each cell i whose bit 2i is 1, and cells with bit 2i clear are passed unchanged.
- R8: The three phase outputs update on the same clock and hold their values between updates.
- R9: A table write with the write enable high stores the data at the given address (0 to 1023). Later reads of that address return it.
- R10: The step sequence wraps from 2047 back to 0, so the pattern repeats every 2048 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_we | input | 1 | Table write enable |
| pat_addr | input | 10 | Table write address |
| pat_data | input | 12 | Table write data |
| div_we | input | 1 | Divisor write enable |
| div_value | input | DIV_W | New divisor (clock cycles per step) |
| phase_a_sw | output | 12 | Phase A switch word |
| phase_b_sw | output | 12 | Phase B switch word |
| phase_c_sw | output | 12 | Phase C switch word |

## Verification
The assertions assume three things. The active divisor never falls below the floor of 4, so a tick cannot arrive while reads are still pending. Table writes do not compete with the read port for the word being fetched. A divisor write never lands on the same clock as a tick. The stimulus fills the whole table while the block is held in reset. It places every divisor write a few clocks after an update and well before the next tick. It runs more than one full period at a divisor of 6, then changes to 9, then writes 2 (which is clamped to 4), and then returns to 6. The bench derives each tick edge from that schedule and checks the outputs one clock before and on the update edge.

// File: rtl/tpps_pkg.sv
// Shared constants and helpers for the three-phase pattern sequencer.
// Assumes a half-period table and six two-bit cells per switch word.
package tpps_pkg;
    parameter int WORD_W  = 12;            // switch word width
    parameter int CELLS   = WORD_W / 2;    // cells per word (on, polarity)
    parameter int STEP_W  = 11;            // step counter width, 2048 steps
    parameter int ADDR_W  = STEP_W - 1;    // half-period table address
    parameter int PHASES  = 3;
    parameter int MIN_DIV = 4;             // reads + commit need four clocks

    typedef enum logic [2:0] {
        SL_IDLE, SL_RD_A, SL_RD_B, SL_RD_C, SL_COMMIT
    } slot_t;

    // Step offset of phase p: p thirds of a period, rounded.
    function automatic int phase_offset(input int p);
        return (p * (1 << STEP_W) + 1) / 3;
    endfunction

    // Negative half: flip polarity of every conducting cell.
    function automatic logic [WORD_W-1:0] fold_word(input logic [WORD_W-1:0] w,
                                                    input logic neg);
        logic [WORD_W-1:0] r;
        r = w;
        for (int i = 0; i < CELLS; i++) begin
            if (neg && w[2*i]) r[2*i+1] = ~w[2*i+1];
        end
        return r;
    endfunction
endpackage

// File: rtl/tpps_divider.sv
// Step tick generator. Counts oscillator clocks and pulses tick every
// active-divisor clocks. A written divisor is held pending until the next
// tick; values below MIN_DIV are raised to MIN_DIV.
// Assumes div_we is not asserted on a tick clock.
module tpps_divider #(
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 407
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_value,
    output logic             tick,
    output logic [DIV_W-1:0] div_act
);
    import tpps_pkg::*;

    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_DIV);
    localparam logic [DIV_W-1:0] RST_V = (DIV_RESET < MIN_DIV) ? FLOOR : DIV_W'(DIV_RESET);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_pend;

    function automatic logic [DIV_W-1:0] clamp(input logic [DIV_W-1:0] v);
        return (v < FLOOR) ? FLOOR : v;
    endfunction

    // tick on the last clock of the interval
    assign tick = (cnt == div_act - 1'b1);

    // interval counter and divisor staging
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            div_act  <= RST_V;
            div_pend <= RST_V;
        end else begin
            if (div_we) div_pend <= clamp(div_value);
            if (tick) begin
                cnt     <= '0;
                div_act <= div_pend;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tpps_step_ctr.sv
// One phase's step counter. Starts at OFFSET after reset and advances by
// one (mod 2^STEP_W) on each advance pulse.
module tpps_step_ctr #(
    parameter int OFFSET = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        advance,
    output logic [tpps_pkg::STEP_W-1:0] step
);
    import tpps_pkg::*;

    // step position, wrapping naturally at the counter width
    always_ff @(posedge clk) begin
        if (!rst_n)       step <= STEP_W'(OFFSET);
        else if (advance) step <= step + 1'b1;
    end
endmodule

// File: rtl/tpps_pattern_mem.sv
// Half-period switch table: one write port for the host, one registered
// read port for the scheduler. A read and a write to the same address on
// the same clock return the old word.
module tpps_pattern_mem (
    input  logic                        clk,
    input  logic                        we,
    input  logic [tpps_pkg::ADDR_W-1:0] waddr,
    input  logic [tpps_pkg::WORD_W-1:0] wdata,
    input  logic                        re,
    input  logic [tpps_pkg::ADDR_W-1:0] raddr,
    output logic [tpps_pkg::WORD_W-1:0] rdata
);
    import tpps_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // host write and registered scheduler read
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/tpps_read_sched.sv
// Read scheduler. After each tick it reads phases A, B, C on three
// consecutive clocks, folds each word by its step's half bit, and loads
// all three output registers together on the fourth clock, which is also
// when the step counters advance.
// Assumes tick never arrives while a read sequence is in flight except on
// the commit clock (guaranteed by the divisor floor).
module tpps_read_sched (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        tick,
    input  logic [tpps_pkg::PHASES-1:0][tpps_pkg::STEP_W-1:0] steps,
    input  logic [tpps_pkg::WORD_W-1:0]                 rdata,
    output logic                                        re,
    output logic [tpps_pkg::ADDR_W-1:0]                 raddr,
    output logic                                        commit,
    output logic [tpps_pkg::PHASES-1:0][tpps_pkg::WORD_W-1:0] outs
);
    import tpps_pkg::*;

    slot_t             slot;
    logic [WORD_W-1:0] cap_a;
    logic [WORD_W-1:0] cap_b;

    assign commit = (slot == SL_COMMIT);

    // address selector: which phase owns the read port this clock
    always_comb begin
        re    = 1'b1;
        raddr = steps[0][ADDR_W-1:0];
        case (slot)
            SL_RD_A: raddr = steps[0][ADDR_W-1:0];
            SL_RD_B: raddr = steps[1][ADDR_W-1:0];
            SL_RD_C: raddr = steps[2][ADDR_W-1:0];
            default: re    = 1'b0;
        endcase
    end

    // slot sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= SL_IDLE;
        end else if (tick) begin
            slot <= SL_RD_A;
        end else begin
            case (slot)
                SL_RD_A: slot <= SL_RD_B;
                SL_RD_B: slot <= SL_RD_C;
                SL_RD_C: slot <= SL_COMMIT;
                default: slot <= SL_IDLE;
            endcase
        end
    end

    // capture folded words and commit all phases together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a <= '0;
            cap_b <= '0;
            outs  <= '0;
        end else begin
            if (slot == SL_RD_B) cap_a <= fold_word(rdata, steps[0][STEP_W-1]);
            if (slot == SL_RD_C) cap_b <= fold_word(rdata, steps[1][STEP_W-1]);
            if (commit) begin
                outs[0] <= cap_a;
                outs[1] <= cap_b;
                outs[2] <= fold_word(rdata, steps[2][STEP_W-1]);
            end
        end
    end
endmodule

// File: rtl/tri_phase_pattern_seq.sv
// Top: three-phase stored-pattern switching sequencer. Divides the clock
// into step ticks, keeps three offset step counters, and replays a
// half-period switch table onto three phase outputs.
// Assumes the table is written while no sequence reads the same address.
module tri_phase_pattern_seq #(
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 407
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pat_we,
    input  logic [tpps_pkg::ADDR_W-1:0] pat_addr,
    input  logic [tpps_pkg::WORD_W-1:0] pat_data,
    input  logic                        div_we,
    input  logic [DIV_W-1:0]            div_value,
    output logic [tpps_pkg::WORD_W-1:0] phase_a_sw,
    output logic [tpps_pkg::WORD_W-1:0] phase_b_sw,
    output logic [tpps_pkg::WORD_W-1:0] phase_c_sw
);
    import tpps_pkg::*;

    logic                                tick;
    logic [DIV_W-1:0]                    div_act;
    logic                                commit;
    logic                                rd_en;
    logic [ADDR_W-1:0]                   rd_addr;
    logic [WORD_W-1:0]                   rd_data;
    logic [PHASES-1:0][STEP_W-1:0]       steps;
    logic [PHASES-1:0][WORD_W-1:0]       outs;

    tpps_divider #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) div_i (
        .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_value(div_value),
        .tick(tick), .div_act(div_act)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        tpps_step_ctr #(.OFFSET(phase_offset(p))) ctr_i (
            .clk(clk), .rst_n(rst_n), .advance(commit), .step(steps[p])
        );
    end

    tpps_pattern_mem mem_i (
        .clk(clk), .we(pat_we), .waddr(pat_addr), .wdata(pat_data),
        .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
    );

    tpps_read_sched sched_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .steps(steps),
        .rdata(rd_data), .re(rd_en), .raddr(rd_addr),
        .commit(commit), .outs(outs)
    );

    assign phase_a_sw = outs[0];
    assign phase_b_sw = outs[1];
    assign phase_c_sw = outs[2];
endmodule

// File: rtl/tpps_checker.sv
// Assertion checker for tri_phase_pattern_seq, attached by bind.
module tpps_checker #(
    parameter int DIV_W = 16
) (
    input logic                                        clk,
    input logic                                        rst_n,
    input logic                                        tick,
    input logic                                        commit,
    input logic [DIV_W-1:0]                            div_act,
    input logic [tpps_pkg::PHASES-1:0][tpps_pkg::STEP_W-1:0] steps,
    input logic [tpps_pkg::WORD_W-1:0]                 phase_a_sw,
    input logic [tpps_pkg::WORD_W-1:0]                 phase_b_sw,
    input logic [tpps_pkg::WORD_W-1:0]                 phase_c_sw
);
    import tpps_pkg::*;

    localparam logic [STEP_W-1:0] OFF_B = STEP_W'(phase_offset(1));
    localparam logic [STEP_W-1:0] OFF_C = STEP_W'(phase_offset(2));

    logic [DIV_W-1:0] gap;

    // clocks since the last tick, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || tick) gap <= '0;
        else if (gap != '1) gap <= gap + 1'b1;
    end

    // R1: reset leaves all outputs off
    a_r1_reset_off: assert property (@(posedge clk)
        !rst_n |=> (phase_a_sw == '0 && phase_b_sw == '0 && phase_c_sw == '0));

    // R2: ticks are at least the floor apart
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> gap >= DIV_W'(MIN_DIV - 1));

    // R3: the active divisor only changes on a tick
    a_r3_div_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(div_act));

    // R4: active divisor never below the floor
    a_r4_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
        div_act >= DIV_W'(MIN_DIV));

    // R6: phase counters keep their offsets
    a_r6_offsets: assert property (@(posedge clk) disable iff (!rst_n)
        (steps[1] - steps[0] == OFF_B) && (steps[2] - steps[0] == OFF_C));

    // R8: outputs move only on a commit clock
    a_r8_outputs_held: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(phase_a_sw) && $stable(phase_b_sw) && $stable(phase_c_sw)));

    // R10: phase A step advances by exactly one, wrapping
    a_r10_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> steps[0] == $past(steps[0]) + 1'b1);
endmodule

bind tri_phase_pattern_seq tpps_checker #(.DIV_W(DIV_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .commit(commit),
    .div_act(div_act), .steps(steps),
    .phase_a_sw(phase_a_sw), .phase_b_sw(phase_b_sw), .phase_c_sw(phase_c_sw)
);

// File: tb/tri_phase_pattern_seq_tb_top.sv
// Sweeps more than one full period and a divisor change sequence, with
// expected words and update edges computed from the requirements.
module tri_phase_pattern_seq_tb_top;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pat_we = 1'b0;
    logic [9:0]    pat_addr = '0;
    logic [11:0]   pat_data = '0;
    logic          div_we = 1'b0;
    logic [DW-1:0] div_value = '0;
    logic [11:0]   phase_a_sw, phase_b_sw, phase_c_sw;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  ecount   = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    tri_phase_pattern_seq #(.DIV_W(DW), .DIV_RESET(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .pat_we(pat_we), .pat_addr(pat_addr),
        .pat_data(pat_data), .div_we(div_we), .div_value(div_value),
        .phase_a_sw(phase_a_sw), .phase_b_sw(phase_b_sw), .phase_c_sw(phase_c_sw)
    );

    always @(posedge clk) begin
        if (!rst_n) ecount <= 0;
        else        ecount <= ecount + 1;
    end

    function automatic logic [11:0] pat(input int a);
        return 12'((a * 29 + 5) ^ (a >> 2) ^ (a << 5));
    endfunction

    // R7 expectation: second half flips polarity of conducting cells
    function automatic logic [11:0] expect_word(input int k, input int off);
        int s;
        logic [11:0] w;
        if (k < 0) return 12'h000;
        s = (k + off) % 2048;
        w = pat(s % 1024);
        if (s >= 1024)
            for (int c = 0; c < 6; c++) if (w[2*c]) w[2*c+1] = ~w[2*c+1];
        return w;
    endfunction

    // interval lengths implied by the divisor write schedule (R3, R4)
    function automatic int interval(input int k);
        if (k <= 2051) return 6;
        if (k <= 2056) return 9;
        if (k <= 2064) return 4;
        return 6;
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at edge %0d", req, act, exp, ecount);
        end
    endtask

    task automatic check_all(input string req, input int k);
        check({req, " phase A R5"}, phase_a_sw, expect_word(k, 0));
        check({req, " phase B R6"}, phase_b_sw, expect_word(k, 683));
        check({req, " phase C R6"}, phase_c_sw, expect_word(k, 1365));
    endtask

    task automatic wait_to(input int t);
        while (ecount < t) @(negedge clk);
    endtask

    task automatic write_div(input int v);
        div_value = DW'(v);
        div_we    = 1'b1;
        @(negedge clk);
        div_we    = 1'b0;
    endtask

    initial begin
        int t;
        // R9: fill the table while held in reset
        for (int a = 0; a < 1024; a++) begin
            @(negedge clk);
            pat_we   = 1'b1;
            pat_addr = 10'(a);
            pat_data = pat(a);
        end
        @(negedge clk);
        pat_we = 1'b0;
        check_all("R1 in reset", -1);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset", -1);
        t = 0;
        for (int k = 0; k < 2072; k++) begin
            t = t + interval(k);
            wait_to(t + 3);
            check_all("R8 R2 hold before update", k - 1);
            wait_to(t + 4);
            check_all((k >= 2048) ? "R10 wrapped update" : "R7 R9 update", k);
            if (k == 2050) write_div(9);
            if (k == 2055) write_div(2);   // R4: clamps to 4
            if (k == 2062) write_div(6);   // R3: lands after the next tick
        end
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R2: actual hung expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule